// File: doc/BRIEF.md
# Predicated Writeback Unit

This unit sits at the register writeback point of a simple in-order pipeline and decides whether each instruction's architectural write takes effect. Every instruction arrives here whatever its guard. The unit evaluates the guard against a small one-bit predicate file and either lets the register write through or drops it. The instruction's work upstream is still done, but its result is discarded when the guard fails.

Four operation kinds are handled: a plain operation that writes the computed result, a move taken only when a test value is zero, a move taken only when a test value is nonzero, and an equality compare. The compare writes no integer register. It writes a pair of predicates with opposite values, so one predicate can guard the "then" arm of an if/else and, used in inverted form, also guard the "else" arm. A predicate written by a compare is staged for one cycle before it commits to the file. The guard read of the following instruction takes the staged value through a bypass.

Top module: `pwb_writeback`

## Requirements
- R1: After reset, predicates 1..7 read as 0 and `wb_we` is 0, so an instruction guarded by predicate 3 in true form does not write, and one guarded by it in inverted form does write.
- R2: When `in_valid` is 1, `in_op` is 0 (plain) and the guard passes, the cycle after the input `wb_we` is 1, `wb_addr` equals `in_rd` and `wb_data` equals `in_result`. When the guard fails, `wb_we` is 0. Whenever `wb_we` is 0, `wb_addr` and `wb_data` are 0.
- R3: The guard passes when the selected predicate value XOR `in_guard_inv` is 1. The same predicate therefore selects opposite arms in its two forms.
- R4: `in_op` = 1 (move-if-zero) writes `in_src` to `in_rd` only when the guard passes and `in_test` is zero.
- R5: `in_op` = 2 (move-if-nonzero) writes `in_src` to `in_rd` only when the guard passes and `in_test` is nonzero.
- R6: `in_op` = 3 (compare) with a passing guard sets predicate `in_pt` to (`in_cmp_a` == `in_cmp_b`) and predicate `in_pf` to the opposite value. It never asserts `wb_we`.
- R7: A compare whose guard fails changes no predicate.
- R8: Predicate 0 always reads as 1, and compare writes to index 0 are ignored.
- R9: A write whose destination is register 0 is dropped (`wb_we` stays 0).
- R10: A predicate written by a compare is seen by the guard of the instruction presented in the very next cycle.
- R11: When `in_pt` equals `in_pf`, that predicate takes the equality result.
- R12: With `in_valid` at 0, no register write occurs and no predicate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | 0 plain, 1 move-if-zero, 2 move-if-nonzero, 3 compare |
| in_rd | input | 5 | Destination integer register |
| in_result | input | 32 | Computed result for a plain operation |
| in_src | input | 32 | Source value for conditional moves |
| in_test | input | 32 | Test value for conditional moves |
| in_cmp_a | input | 32 | First compare operand |
| in_cmp_b | input | 32 | Second compare operand |
| in_guard_idx | input | 3 | Guarding predicate index |
| in_guard_inv | input | 1 | Use guard in inverted form |
| in_pt | input | 3 | Predicate set to 1 on equality |
| in_pf | input | 3 | Predicate set to 1 on inequality |
| wb_we | output | 1 | Register write enable |
| wb_addr | output | 5 | Register write address |
| wb_data | output | 32 | Register write data |

## Verification
Two functions meet in the same cycle: the commit of a staged compare result into the predicate file, and the guard read of the next instruction, which must take the staged value through the bypass rather than the stale stored value. The bench issues compares back to back with guarded operations and with further compares. Predicate indices, guards and inversion are drawn from a long pseudo-random sweep, so a guard often names a predicate that is being committed in that cycle. Each writeback is judged against a bench model whose predicate array is updated immediately when a compare is issued, which is exactly the visibility the bypass promises.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_MOVZ  = 2'd1,
    OP_MOVNZ = 2'd2,
    OP_CMPEQ = 2'd3
  } pwb_op_e;

  // Guard outcome: predicate value, optionally inverted.
  function automatic logic guard_pass(input logic pval, input logic inv);
    return pval ^ inv;
  endfunction

  // Whether an operation wants an integer register write, given the test.
  function automatic logic op_wants_write(input pwb_op_e op, input logic test_is_zero);
    logic w;
    case (op)
      OP_PLAIN: w = 1'b1;
      OP_MOVZ:  w = test_is_zero;
      OP_MOVNZ: w = !test_is_zero;
      default:  w = 1'b0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pwb_pred_file.sv
module pwb_pred_file
  import pwb_pkg::*;
#(
  parameter int NPRED = 8,
  localparam int PA_W = $clog2(NPRED)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] rd_idx,
  output logic            rd_val,
  input  logic            set_en,
  input  logic [PA_W-1:0] set_t,
  input  logic [PA_W-1:0] set_f,
  input  logic            set_eq
);

  // Staged compare result, committed one edge later.
  logic            pend_v;
  logic [PA_W-1:0] pend_t;
  logic [PA_W-1:0] pend_f;
  logic            pend_eq;
  logic            arch_q [NPRED];
  logic            byp_hit_t;
  logic            byp_hit_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_t  <= '0;
      pend_f  <= '0;
      pend_eq <= 1'b0;
    end else begin
      pend_v  <= set_en;
      pend_t  <= set_t;
      pend_f  <= set_f;
      pend_eq <= set_eq;
    end
  end

  for (genvar i = 0; i < NPRED; i++) begin : g_entry
    if (i == 0) begin : g_const
      assign arch_q[i] = 1'b1;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          arch_q[i] <= 1'b0;
        else if (pend_v && pend_t == PA_W'(i))
          arch_q[i] <= pend_eq;
        else if (pend_v && pend_f == PA_W'(i))
          arch_q[i] <= !pend_eq;
      end
    end
  end

  assign byp_hit_t = pend_v && (pend_t == rd_idx);
  assign byp_hit_f = pend_v && (pend_f == rd_idx);

  always_comb begin
    if (rd_idx == '0)     rd_val = 1'b1;
    else if (byp_hit_t)   rd_val = pend_eq;
    else if (byp_hit_f)   rd_val = !pend_eq;
    else                  rd_val = arch_q[rd_idx];
  end

  // R6: a staged compare lands in the "true" slot with its equality result
  assert_commit_true_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && pend_t != '0) |=> (arch_q[$past(pend_t)] == $past(pend_eq)));

  // R6: distinct nonzero slots of one compare end up complementary
  assert_pair_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && pend_t != pend_f && pend_t != '0 && pend_f != '0)
      |=> (arch_q[$past(pend_t)] != arch_q[$past(pend_f)]));

  // R12: with nothing staged, the stored predicates hold
  assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_v |=> $stable(arch_q[1]) && $stable(arch_q[NPRED-1]));

endmodule

// File: rtl/pwb_guard_eval.sv
module pwb_guard_eval
  import pwb_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RA_W = 5
) (
  input  logic            valid,
  input  pwb_op_e         op,
  input  logic            pval,
  input  logic            inv,
  input  logic [RA_W-1:0] rd,
  input  logic [XLEN-1:0] result,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] test,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  output logic            guard_ok,
  output logic            do_wr,
  output logic [RA_W-1:0] wr_addr,
  output logic [XLEN-1:0] wr_data,
  output logic            do_pset,
  output logic            pset_eq
);

  logic test_zero;
  logic want_wr;

  assign test_zero = (test == '0);
  assign guard_ok  = valid && guard_pass(pval, inv);
  assign want_wr   = op_wants_write(op, test_zero);
  assign do_wr     = guard_ok && want_wr && (rd != '0);
  assign wr_addr   = do_wr ? rd : '0;

  always_comb begin
    if (!do_wr)              wr_data = '0;
    else if (op == OP_PLAIN) wr_data = result;
    else                     wr_data = src;
  end

  assign do_pset = guard_ok && (op == OP_CMPEQ);
  assign pset_eq = (cmp_a == cmp_b);

endmodule

// File: rtl/pwb_writeback.sv
module pwb_writeback
  import pwb_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int NPRED = 8,
  localparam int RA_W = $clog2(NREG),
  localparam int PA_W = $clog2(NPRED)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [RA_W-1:0] in_rd,
  input  logic [XLEN-1:0] in_result,
  input  logic [XLEN-1:0] in_src,
  input  logic [XLEN-1:0] in_test,
  input  logic [XLEN-1:0] in_cmp_a,
  input  logic [XLEN-1:0] in_cmp_b,
  input  logic [PA_W-1:0] in_guard_idx,
  input  logic            in_guard_inv,
  input  logic [PA_W-1:0] in_pt,
  input  logic [PA_W-1:0] in_pf,
  output logic            wb_we,
  output logic [RA_W-1:0] wb_addr,
  output logic [XLEN-1:0] wb_data
);

  pwb_op_e         op_dec;
  logic            guard_val;
  logic            guard_ok;
  logic            do_wr;
  logic [RA_W-1:0] wr_addr;
  logic [XLEN-1:0] wr_data;
  logic            do_pset;
  logic            pset_eq;

  assign op_dec = pwb_op_e'(in_op);

  pwb_pred_file #(.NPRED(NPRED)) pfile_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (in_guard_idx),
    .rd_val (guard_val),
    .set_en (do_pset),
    .set_t  (in_pt),
    .set_f  (in_pf),
    .set_eq (pset_eq)
  );

  pwb_guard_eval #(.XLEN(XLEN), .RA_W(RA_W)) geval_i (
    .valid    (in_valid),
    .op       (op_dec),
    .pval     (guard_val),
    .inv      (in_guard_inv),
    .rd       (in_rd),
    .result   (in_result),
    .src      (in_src),
    .test     (in_test),
    .cmp_a    (in_cmp_a),
    .cmp_b    (in_cmp_b),
    .guard_ok (guard_ok),
    .do_wr    (do_wr),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .do_pset  (do_pset),
    .pset_eq  (pset_eq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_we   <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
    end else begin
      wb_we   <= do_wr;
      wb_addr <= wr_addr;
      wb_data <= wr_data;
    end
  end

  // R9: register 0 is never written
  assert_no_zero_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (wb_addr != '0));

  // R6: a compare never produces a register write
  assert_cmp_no_regwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd3) |=> !wb_we);

  // R12: an idle slot writes nothing
  assert_idle_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wb_we);

  // R4: a move-if-zero with a nonzero test writes nothing
  assert_movz_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd1 && in_test != '0) |=> !wb_we);

  // R5: a move-if-nonzero with a zero test writes nothing
  assert_movnz_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd2 && in_test == '0) |=> !wb_we);

  // R2: with no write, the address and data are quiet
  assert_quiet_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_we |-> (wb_addr == '0 && wb_data == '0));

  // R7: a failed guard produces no write of either kind
  assert_failed_guard_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!guard_ok) |-> (!do_pset && !do_wr));

endmodule

// File: tb/pwb_writeback_tb_top.sv
`timescale 1ns/1ps
module pwb_writeback_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = '0;
  logic [4:0]  in_rd = '0;
  logic [31:0] in_result = '0, in_src = '0, in_test = '0, in_cmp_a = '0, in_cmp_b = '0;
  logic [2:0]  in_guard_idx = '0;
  logic        in_guard_inv = 1'b0;
  logic [2:0]  in_pt = '0, in_pf = '0;
  logic        wb_we;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic m_pred [8];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  pwb_writeback dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_rd(in_rd),
    .in_result(in_result), .in_src(in_src), .in_test(in_test),
    .in_cmp_a(in_cmp_a), .in_cmp_b(in_cmp_b), .in_guard_idx(in_guard_idx),
    .in_guard_inv(in_guard_inv), .in_pt(in_pt), .in_pf(in_pf),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Called at a falling edge: drive one slot, wait a cycle, check its writeback.
  task automatic issue(input string req, input logic v, input logic [1:0] op,
                       input logic [4:0] rd, input logic [31:0] res, input logic [31:0] src,
                       input logic [31:0] tst, input logic [31:0] ca, input logic [31:0] cb,
                       input logic [2:0] gi, input logic ginv,
                       input logic [2:0] pt, input logic [2:0] pf);
    logic g, ok, we;
    logic [31:0] d;
    in_valid = v; in_op = op; in_rd = rd; in_result = res; in_src = src;
    in_test = tst; in_cmp_a = ca; in_cmp_b = cb; in_guard_idx = gi;
    in_guard_inv = ginv; in_pt = pt; in_pf = pf;
    g  = (gi == 3'd0) ? 1'b1 : m_pred[gi];
    ok = v && (g ^ ginv);
    we = 1'b0;
    d  = 32'h0;
    case (op)
      2'd0: begin we = ok && rd != 0; d = res; end
      2'd1: begin we = ok && rd != 0 && tst == 0; d = src; end
      2'd2: begin we = ok && rd != 0 && tst != 0; d = src; end
      default: begin
        if (ok) begin
          if (pf != 0) m_pred[pf] = (ca != cb);
          if (pt != 0) m_pred[pt] = (ca == cb);
        end
      end
    endcase
    @(negedge clk);
    check({req, " we"}, 64'(wb_we), 64'(we));
    check({req, " addr"}, 64'(wb_addr), we ? 64'(rd) : 64'h0);
    check({req, " data"}, 64'(wb_data), we ? 64'(d) : 64'h0);
  endtask

  task automatic cmp(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [2:0] gi, input logic ginv, input logic [2:0] pt, input logic [2:0] pf);
    issue(req, 1'b1, 2'd3, 5'd9, 32'h0, 32'h0, 32'h0, a, b, gi, ginv, pt, pf);
  endtask

  task automatic plain(input string req, input logic [4:0] rd, input logic [31:0] v,
                       input logic [2:0] gi, input logic ginv);
    issue(req, 1'b1, 2'd0, rd, v, 32'h0, 32'h0, 32'h0, 32'h0, gi, ginv, 3'd0, 3'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_pred[i] = (i == 0);
    repeat (3) @(negedge clk);
    check("R1 reset we", 64'(wb_we), 64'h0);
    rst_n = 1'b1;

    // R1: predicate 3 starts cleared
    plain("R1 true-form", 5'd4, 32'h1111, 3'd3, 1'b0);
    plain("R1 inverted-form", 5'd4, 32'h2222, 3'd3, 1'b1);
    // R8: predicate 0 always passes; R9 register 0 dropped
    plain("R8 p0 guard", 5'd7, 32'hCAFE, 3'd0, 1'b0);
    plain("R9 rd zero", 5'd0, 32'hDEAD, 3'd0, 1'b0);
    // R10: compare then immediate use; R6 pair complement; R3 inversion
    cmp("R6 cmp eq", 32'd5, 32'd5, 3'd0, 1'b0, 3'd2, 3'd3);
    plain("R10 bypass t", 5'd5, 32'h55, 3'd2, 1'b0);
    plain("R3 inv f", 5'd6, 32'h66, 3'd3, 1'b1);
    plain("R6 f cleared", 5'd6, 32'h67, 3'd3, 1'b0);
    // R7: failed-guard compare leaves p2/p3 untouched
    cmp("R7 blocked cmp", 32'd1, 32'd2, 3'd4, 1'b0, 3'd3, 3'd2);
    plain("R7 p2 kept", 5'd8, 32'h88, 3'd2, 1'b0);
    // R8: writes to p0 ignored
    cmp("R8 write p0", 32'd1, 32'd2, 3'd0, 1'b0, 3'd0, 3'd5);
    plain("R8 p0 still true", 5'd8, 32'h89, 3'd0, 1'b0);
    // R11: same index gets equality result
    cmp("R11 same idx", 32'd3, 32'd3, 3'd0, 1'b0, 3'd6, 3'd6);
    plain("R11 p6 set", 5'd10, 32'hA0, 3'd6, 1'b0);
    // R4/R5 directed
    issue("R4 movz zero", 1'b1, 2'd1, 5'd11, 32'h0, 32'hB1, 32'h0, 32'h0, 32'h0, 3'd0, 1'b0, 3'd0, 3'd0);
    issue("R4 movz nz", 1'b1, 2'd1, 5'd11, 32'h0, 32'hB2, 32'h4, 32'h0, 32'h0, 3'd0, 1'b0, 3'd0, 3'd0);
    issue("R5 movn nz", 1'b1, 2'd2, 5'd12, 32'h0, 32'hC1, 32'h4, 32'h0, 32'h0, 3'd0, 1'b0, 3'd0, 3'd0);
    issue("R5 movn zero", 1'b1, 2'd2, 5'd12, 32'h0, 32'hC2, 32'h0, 32'h0, 32'h0, 3'd0, 1'b0, 3'd0, 3'd0);
    // R12: idle slot with compare fields does nothing
    issue("R12 idle", 1'b0, 2'd3, 5'd13, 32'h1, 32'h1, 32'h0, 32'h1, 32'h1, 3'd0, 1'b0, 3'd2, 3'd3);
    plain("R12 p3 kept", 5'd13, 32'hD0, 3'd3, 1'b0);

    // Sweep: random op mix, back-to-back, covering bypass and commit collisions (R2 R3 R10)
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r1, r2, r3;
      lfsr = next_rand(lfsr); r1 = lfsr;
      lfsr = next_rand(lfsr); r2 = lfsr;
      lfsr = next_rand(lfsr); r3 = lfsr;
      issue("R2 sweep", r1[31:29] != 3'd0, r1[1:0], r1[6:2] & {5{r1[28]|r1[27]}}, r2, r3,
            r1[7] ? 32'h0 : r2 ^ r3, r2, r1[8] ? r2 : r3,
            r1[11:9], r1[12], r1[15:13], r1[18:16]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule